// File: doc/BRIEF.md
# Exact-Match MAC Address Filter Table

This block holds a table of sixteen programmable 48-bit station addresses. It is used in the receive path of an Ethernet controller. For each incoming frame, the frame parser presents the destination and source addresses together with a strobe. One cycle later the table reports whether any enabled entry matched, and which one. Each entry carries a two-bit selector that decides which of the two frame addresses it is compared against. An entry takes part in comparison only while its enable bit is set.

Software reaches the table through a 32-bit word register port. Each entry occupies two consecutive words: the lower 32 address bits first, then a control word that holds the upper 16 address bits, the selector and the enable. The same storage appears at two address windows: a primary window and a compatibility alias window.

Entry 0 has two extra roles. Its destination match also drives a dedicated flag for pause-frame recognition. It can also be filled in one cycle from a non-volatile memory loader, which leaves it enabled and comparing against destination addresses. The enable bit of the last entry survives the ordinary master reset and is cleared only by the power-on reset.

Top module: `mac_filt`

## Requirements
- R1: Address bits 31:0 of entry i are read and written at word offset 8*i of a window. The word at 8*i+4 holds address bits 47:32 in bits 15:0, the selector in bits 17:16 and the enable in bit 31.
- R2: Bits 30:18 of the control word read as zero, and values written to them have no effect.
- R3: The primary window starts at byte address PRIM_BASE (default 0x5400). The alias window covers 0x040 to 0x0BF. Both windows reach the same storage, so a write through either window is read back through the other.
- R4: Selector 00 compares the entry against the frame destination address, and selector 01 compares it against the frame source address.
- R5: An entry whose selector is 10 or 11 never matches, even while enabled.
- R6: An entry whose enable bit is 0 never matches.
- R7: A compare strobe produces match_valid one cycle later. It also produces match_hit and, when several entries match, the lowest matching index on match_idx (0 when nothing matches). No strobe means no valid or hit.
- R8: pause_hit rises together with match_valid when entry 0 is enabled, has selector 00 and equals the frame destination address.
- R9: Master reset clears the enable bits of entries 0 to 14 and leaves the enable bit of entry 15 unchanged. Register writes are ignored while either reset is active.
- R10: Power-on reset clears the enable bits of all entries, including entry 15.
- R11: A load pulse writes nvm_mac into entry 0, with selector 00 and enable 1.
- R12: A load pulse in the same cycle as a software write to entry 0 wins, and the software write is discarded.
- R13: Addresses outside both windows, or not word aligned, read as zero, and writes to them change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high |
| por_rst | input | 1 | Synchronous power-on reset, active high |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| nvm_load | input | 1 | One-cycle station address load into entry 0 |
| nvm_mac | input | 48 | Station address from non-volatile memory |
| cmp_valid | input | 1 | Compare request strobe |
| cmp_da | input | 48 | Frame destination address |
| cmp_sa | input | 48 | Frame source address |
| match_valid | output | 1 | Compare result valid (one cycle after strobe) |
| match_hit | output | 1 | At least one enabled entry matched |
| match_idx | output | 4 | Lowest matching entry index |
| pause_hit | output | 1 | Destination matched entry 0 |

## Verification
The hardest state to reach from the ports is entry 15 enabled across a master reset, with a register write attempted during that reset. The stimulus enables every entry, holds rst high while writing a cleared control word to entry 15, and then confirms that entry 15 still reads enabled and still matches while entries 0 to 14 no longer do. A second hard case is the load pulse colliding with a software write to entry 0. This collision is driven in a single cycle and then observed through readback and a pause-frame compare.

// File: rtl/mac_filt_pkg.sv
package mac_filt_pkg;

    localparam int MAC_W  = 48;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SEL_DA   = 2'b00,
        SEL_SA   = 2'b01,
        SEL_RSV2 = 2'b10,
        SEL_RSV3 = 2'b11
    } addr_sel_e;

    typedef struct packed {
        logic             valid;
        addr_sel_e        sel;
        logic [MAC_W-1:0] mac;
    } entry_t;

    // Control word: {enable, 13'b0, selector, mac[47:32]}
    function automatic logic [WORD_W-1:0] pack_ctrl(entry_t e);
        return {e.valid, 13'b0, e.sel, e.mac[47:32]};
    endfunction

    // True when an entry compares equal against the address its selector picks
    function automatic logic entry_hit(entry_t e, logic [MAC_W-1:0] da,
                                       logic [MAC_W-1:0] sa);
        logic r;
        case (e.sel)
            SEL_DA:  r = (e.mac == da);
            SEL_SA:  r = (e.mac == sa);
            default: r = 1'b0;
        endcase
        return e.valid && r;
    endfunction

endpackage

// File: rtl/mac_filt_table.sv
module mac_filt_table
    import mac_filt_pkg::*;
#(
    parameter int             N          = 16,
    parameter int             AW         = 16,
    parameter logic [AW-1:0]  PRIM_BASE  = 16'h5400,
    parameter logic [AW-1:0]  ALIAS_BASE = 16'h0040
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 por_rst,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    rdata,
    input  logic                 nvm_load,
    input  logic [MAC_W-1:0]     nvm_mac,
    output entry_t [N-1:0]       tab
);
    localparam int            IDX_W  = $clog2(N);
    localparam logic [AW-1:0] SPAN_W = AW'(N * 8);

    logic [AW-1:0]    off_p, off_a, off;
    logic             in_p, in_a, acc_hit, acc_hi, wr_ok;
    logic [IDX_W-1:0] acc_idx;
    logic [N-1:0]     vld_vec;

    always_comb begin
        off_p   = addr - PRIM_BASE;
        off_a   = addr - ALIAS_BASE;
        in_p    = (addr >= PRIM_BASE) && (off_p < SPAN_W);
        in_a    = (addr >= ALIAS_BASE) && (off_a < SPAN_W);
        off     = in_p ? off_p : off_a;
        acc_hit = (in_p || in_a) && (off[1:0] == 2'b00);
        acc_idx = off[IDX_W+2:3];
        acc_hi  = off[2];
        wr_ok   = wr_en && acc_hit && !rst && !por_rst;
    end

    for (genvar i = 0; i < N; i++) begin : g_ent
        localparam bit IS_LAST  = (i == N - 1);
        localparam bit IS_FIRST = (i == 0);
        entry_t ent_q;

        always_ff @(posedge clk) begin
            if (por_rst) begin
                ent_q.valid <= 1'b0;
            end else if (rst) begin
                if (!IS_LAST) ent_q.valid <= 1'b0;
            end else if (IS_FIRST && nvm_load) begin
                ent_q.mac   <= nvm_mac;
                ent_q.sel   <= SEL_DA;
                ent_q.valid <= 1'b1;
            end else if (wr_ok && (acc_idx == IDX_W'(i))) begin
                if (acc_hi) begin
                    ent_q.mac[47:32] <= wdata[15:0];
                    ent_q.sel        <= addr_sel_e'(wdata[17:16]);
                    ent_q.valid      <= wdata[31];
                end else begin
                    ent_q.mac[31:0]  <= wdata;
                end
            end
        end

        assign tab[i]     = ent_q;
        assign vld_vec[i] = ent_q.valid;
    end

    always_comb begin
        rdata = '0;
        if (acc_hit) begin
            rdata = acc_hi ? pack_ctrl(tab[acc_idx]) : tab[acc_idx].mac[31:0];
        end
    end

    // Master reset clears enables below the last entry
    assert_mrst_clears_R9: assert property (@(posedge clk) disable iff (por_rst)
        rst |=> (vld_vec[N-2:0] == '0));

    // Master reset and blocked writes leave the last enable untouched
    assert_last_keeps_R9: assert property (@(posedge clk) disable iff (por_rst)
        rst |=> $stable(vld_vec[N-1]));

    // Power-on reset clears every enable
    assert_por_clears_R10: assert property (@(posedge clk) disable iff (1'b0)
        por_rst |=> (vld_vec == '0));

    // Load pulse leaves entry 0 enabled, destination-compared, holding the loaded address
    assert_nvm_load_R11: assert property (@(posedge clk) disable iff (rst || por_rst)
        nvm_load |=> (vld_vec[0] && tab[0].sel == SEL_DA && tab[0].mac == $past(nvm_mac)));

endmodule

// File: rtl/mac_filt_cmp.sv
module mac_filt_cmp
    import mac_filt_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst,
    input  entry_t [N-1:0]     tab,
    input  logic               cmp_valid,
    input  logic [MAC_W-1:0]   cmp_da,
    input  logic [MAC_W-1:0]   cmp_sa,
    output logic               match_valid,
    output logic               match_hit,
    output logic [IDX_W-1:0]   match_idx,
    output logic               pause_hit
);
    logic [N-1:0]     hit_vec;
    logic             found;
    logic [IDX_W-1:0] first_idx;
    logic             pause_c;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            hit_vec[i] = entry_hit(tab[i], cmp_da, cmp_sa);
        end
        found     = 1'b0;
        first_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                found     = 1'b1;
                first_idx = IDX_W'(i);
            end
        end
        pause_c = tab[0].valid && (tab[0].sel == SEL_DA) && (tab[0].mac == cmp_da);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_valid <= 1'b0;
            match_hit   <= 1'b0;
            match_idx   <= '0;
            pause_hit   <= 1'b0;
        end else begin
            match_valid <= cmp_valid;
            match_hit   <= cmp_valid && found;
            match_idx   <= (cmp_valid && found) ? first_idx : '0;
            pause_hit   <= cmp_valid && pause_c;
        end
    end

    // A pause match is always also the lowest-index hit
    assert_pause_is_idx0_R8: assert property (@(posedge clk) disable iff (rst)
        pause_hit |-> (match_hit && match_idx == '0));

    // Results appear only one cycle after a strobe
    assert_hit_needs_req_R7: assert property (@(posedge clk) disable iff (rst)
        match_hit |-> $past(cmp_valid));

    // No hit reported means the index rests at zero
    assert_idle_idx_R7: assert property (@(posedge clk) disable iff (rst)
        !match_hit |-> (match_idx == '0));

endmodule

// File: rtl/mac_filt.sv
module mac_filt
    import mac_filt_pkg::*;
#(
    parameter int            N          = 16,
    parameter logic [15:0]   PRIM_BASE  = 16'h5400,
    parameter logic [15:0]   ALIAS_BASE = 16'h0040
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        por_rst,
    input  logic        reg_wen,
    input  logic [15:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        nvm_load,
    input  logic [47:0] nvm_mac,
    input  logic        cmp_valid,
    input  logic [47:0] cmp_da,
    input  logic [47:0] cmp_sa,
    output logic        match_valid,
    output logic        match_hit,
    output logic [3:0]  match_idx,
    output logic        pause_hit
);
    entry_t [N-1:0] tab;
    logic           any_rst;

    assign any_rst = rst || por_rst;

    mac_filt_table #(
        .N(N), .AW(16), .PRIM_BASE(PRIM_BASE), .ALIAS_BASE(ALIAS_BASE)
    ) u_table (
        .clk(clk), .rst(rst), .por_rst(por_rst),
        .wr_en(reg_wen), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .nvm_load(nvm_load), .nvm_mac(nvm_mac), .tab(tab)
    );

    mac_filt_cmp #(.N(N), .IDX_W(4)) u_cmp (
        .clk(clk), .rst(any_rst), .tab(tab),
        .cmp_valid(cmp_valid), .cmp_da(cmp_da), .cmp_sa(cmp_sa),
        .match_valid(match_valid), .match_hit(match_hit),
        .match_idx(match_idx), .pause_hit(pause_hit)
    );

endmodule

// File: tb/mac_filt_bench.sv
module mac_filt_bench;
    localparam logic [15:0] PB = 16'h5400;
    localparam logic [15:0] AB = 16'h0040;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por_rst = 1'b1;
    logic        reg_wen = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        nvm_load = 1'b0;
    logic [47:0] nvm_mac = '0;
    logic        cmp_valid = 1'b0;
    logic [47:0] cmp_da = '0;
    logic [47:0] cmp_sa = '0;
    logic        match_valid, match_hit, pause_hit;
    logic [3:0]  match_idx;

    int checks = 0;
    int errors = 0;

    logic [47:0] m_mac [16];
    logic [1:0]  m_sel [16];
    logic        m_v   [16];

    always #10 clk = ~clk;

    mac_filt u_mac_filt (
        .clk(clk), .rst(rst), .por_rst(por_rst),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .nvm_load(nvm_load), .nvm_mac(nvm_mac),
        .cmp_valid(cmp_valid), .cmp_da(cmp_da), .cmp_sa(cmp_sa),
        .match_valid(match_valid), .match_hit(match_hit),
        .match_idx(match_idx), .pause_hit(pause_hit)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [47:0] mac_of(input int j);
        return {16'h0A00 | 16'(j), 32'h5EED_0000 | 32'(j * 17)};
    endfunction

    function automatic logic [15:0] ad(input logic [15:0] base, input int i, input bit hi);
        return base + 16'(i * 8) + (hi ? 16'd4 : 16'd0);
    endfunction

    function automatic logic [31:0] exp_rd(input int i, input bit hi);
        return hi ? {m_v[i], 13'b0, m_sel[i], m_mac[i][47:32]} : m_mac[i][31:0];
    endfunction

    task automatic wr(input logic [15:0] base, input int i, input bit hi, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = ad(base, i, hi); reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
        if (hi) begin
            m_mac[i][47:32] = d[15:0]; m_sel[i] = d[17:16]; m_v[i] = d[31];
        end else begin
            m_mac[i][31:0] = d;
        end
    endtask

    task automatic set_entry(input int i, input logic [47:0] mac, input logic [1:0] sel,
                             input bit v, input bit rsv_ones);
        wr(PB, i, 1'b0, mac[31:0]);
        wr(AB, i, 1'b1, {v, rsv_ones ? 13'h1FFF : 13'h0, sel, mac[47:32]});
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic cmp_chk(input string req, input logic [47:0] da, input logic [47:0] sa);
        bit       hit = 1'b0;
        bit       pz;
        int       idx = 0;
        @(negedge clk);
        cmp_valid = 1'b1; cmp_da = da; cmp_sa = sa;
        for (int j = 15; j >= 0; j--) begin
            if (m_v[j] && ((m_sel[j] == 2'b00 && m_mac[j] == da) ||
                           (m_sel[j] == 2'b01 && m_mac[j] == sa))) begin
                hit = 1'b1; idx = j;
            end
        end
        pz = m_v[0] && m_sel[0] == 2'b00 && m_mac[0] == da;
        @(negedge clk);
        cmp_valid = 1'b0;
        check({req, " valid"}, 64'(match_valid), 64'd1);
        check({req, " hit/idx/pause"}, {57'b0, match_hit, match_idx, pause_hit},
              {57'b0, hit, 4'(idx), pz});
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_mac[i] = '0; m_sel[i] = 2'b00; m_v[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        por_rst = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R7 reset outputs", {60'b0, match_valid, match_hit, pause_hit, 1'b0}, 64'd0);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); reg_addr = ad(PB, i, 1'b1); #1;
            check("R10 enable clear after power-on", 64'(reg_rdata[31]), 64'd0);
        end

        // R1 R2 R3 R5: selectors cycle through all four codes, reserved bits written as ones
        for (int i = 0; i < 16; i++) set_entry(i, mac_of(i), 2'(i % 4), 1'b1, 1'b1);
        for (int i = 0; i < 16; i++) begin
            rd_chk("R1 R2 low word primary", ad(PB, i, 1'b0), exp_rd(i, 1'b0));
            rd_chk("R1 R2 control word primary", ad(PB, i, 1'b1), exp_rd(i, 1'b1));
            rd_chk("R3 low word alias", ad(AB, i, 1'b0), exp_rd(i, 1'b0));
            rd_chk("R3 control word alias", ad(AB, i, 1'b1), exp_rd(i, 1'b1));
        end
        for (int j = 0; j < 16; j++) cmp_chk("R5 R4 both fields", mac_of(j), mac_of(j));

        // R4: alternate destination/source selectors
        for (int i = 0; i < 16; i++) set_entry(i, mac_of(i), 2'(i % 2), 1'b1, 1'b0);
        for (int j = 0; j < 16; j++) begin
            cmp_chk("R4 destination only", mac_of(j), 48'h0);
            cmp_chk("R4 source only", 48'h0, mac_of(j));
        end
        cmp_chk("R7 no match", 48'h0, 48'h0);

        // R7 priority and R6 enable gating
        set_entry(5, mac_of(9), 2'b01, 1'b1, 1'b0);
        cmp_chk("R7 lowest index wins", 48'h0, mac_of(9));
        set_entry(5, mac_of(9), 2'b01, 1'b0, 1'b0);
        cmp_chk("R6 disabled entry skipped", 48'h0, mac_of(9));
        cmp_chk("R8 pause on entry 0", mac_of(0), 48'h0);
        set_entry(0, mac_of(0), 2'b01, 1'b1, 1'b0);
        cmp_chk("R8 no pause with source selector", mac_of(0), mac_of(0));

        // R13 unmapped and misaligned
        rd_chk("R13 unmapped read", 16'h0000, 32'h0);
        rd_chk("R13 above primary read", PB + 16'h0080, 32'h0);
        rd_chk("R13 misaligned read", PB + 16'h0002, 32'h0);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = PB + 16'h0080; reg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        reg_addr = PB + 16'h0001;
        @(negedge clk);
        reg_wen = 1'b0;
        for (int i = 0; i < 16; i++) rd_chk("R13 table unchanged", ad(PB, i, 1'b1), exp_rd(i, 1'b1));

        // R9 master reset with a blocked write to entry 15
        set_entry(0, mac_of(0), 2'b00, 1'b1, 1'b0);
        @(negedge clk);
        rst = 1'b1; reg_wen = 1'b1; reg_addr = ad(PB, 15, 1'b1); reg_wdata = 32'h0;
        @(negedge clk);
        rst = 1'b0; reg_wen = 1'b0;
        for (int i = 0; i < 15; i++) m_v[i] = 1'b0;
        for (int i = 0; i < 16; i++) rd_chk("R9 enables after master reset", ad(PB, i, 1'b1), exp_rd(i, 1'b1));
        cmp_chk("R9 last entry still matches", mac_of(15), mac_of(15));
        cmp_chk("R9 entry 0 cleared", mac_of(0), mac_of(0));

        // R11 R12 load collides with a software write to entry 0
        @(negedge clk);
        nvm_load = 1'b1; nvm_mac = 48'h00AA_BB11_2233;
        reg_wen = 1'b1; reg_addr = ad(PB, 0, 1'b0); reg_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        nvm_load = 1'b0; reg_wen = 1'b0;
        m_mac[0] = 48'h00AA_BB11_2233; m_sel[0] = 2'b00; m_v[0] = 1'b1;
        rd_chk("R12 load wins over write", ad(PB, 0, 1'b0), exp_rd(0, 1'b0));
        rd_chk("R11 loaded control word", ad(AB, 0, 1'b1), exp_rd(0, 1'b1));
        cmp_chk("R11 R8 loaded station address", 48'h00AA_BB11_2233, 48'h0);

        // R10 power-on reset clears entry 15
        @(negedge clk);
        por_rst = 1'b1;
        @(negedge clk);
        por_rst = 1'b0;
        for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
        rd_chk("R10 last enable cleared", ad(PB, 15, 1'b1), exp_rd(15, 1'b1));
        cmp_chk("R10 no match after power-on", mac_of(15), mac_of(15));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule